// File: doc/BRIEF.md
# Multi-Mode Digital Trigger Unit

This block decides when a waveform acquisition begins. It watches a stream of 6-bit sample codes and an external trigger line. After it is armed, it emits a single-cycle start pulse to the capture sequencer. Four settings choose what starts a capture: a hysteresis crossing of one of five fixed thresholds (rising or falling), an edge on the external line (rising or falling), or automatic mode. Automatic mode waits for a rising crossing and forces a start if none arrives within a timeout.

Every start also drives a stretched trigger output. Several channels can then be cascaded: a master's trigger output feeds the external trigger inputs of its slaves, which synchronize and edge-detect it. Each arming yields at most one start. Later activity is ignored until the unit is armed again.

Top module: `acq_trigger`

## Requirements
- R1: After synchronous reset, `trig_pulse` and `trig_out` are low and the unit is disarmed. No sample or external edge produces a pulse until `arm` is asserted.
- R2: `level_sel` codes 0,1,2,3,4 select the thresholds 8, 20, 32, 44 and 56. Codes 5, 6 and 7 select 56.
- R3: In mode 1 (internal rising), a valid sample at or below level−2 primes the unit. A later valid sample at or above level+2 triggers it. `trig_pulse` goes high in the cycle after that sample is taken. Samples between the two bounds neither prime nor trigger.
- R4: In mode 2 (internal falling), the rule is reversed. A valid sample at or above level+2 primes the unit, and a later valid sample at or below level−2 triggers it, with the same one-cycle latency.
- R5: A sample presented while `sample_vld` is low neither primes nor triggers.
- R6: Each arming produces exactly one `trig_pulse`, one cycle wide. Crossings and edges after it are ignored until `arm` is asserted again.
- R7: In mode 3 (external rising), a 0→1 change on `ext_trig_in` that settles before a clock edge raises `trig_pulse` after the third rising edge that follows.
- R8: In mode 4 (external falling), a 1→0 change on `ext_trig_in` does the same. External edges while disarmed are ignored.
- R9: In mode 0 (automatic), a rising crossing by the R3 rule triggers early. Otherwise `trig_pulse` rises exactly AUTO_TIMEOUT (default 65536) clock edges after the edge that sampled `arm`.
- R10: `trig_out` rises together with `trig_pulse` and stays high for exactly STRETCH (default 4) cycles.
- R11: Mode codes 5, 6 and 7 never trigger, whatever the samples, the external line or the elapsed time.
- R12: Asserting `arm` again clears any priming from the R3/R4 rules and restarts the automatic timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | Arm (or re-arm) request, sampled each edge |
| mode | input | 3 | Trigger source select (0 auto, 1 rise, 2 fall, 3 ext rise, 4 ext fall) |
| level_sel | input | 3 | Threshold select |
| sample | input | 6 | Signal sample code |
| sample_vld | input | 1 | Sample qualifier |
| ext_trig_in | input | 1 | External trigger line, asynchronous |
| trig_pulse | output | 1 | Single-cycle start pulse to the capture sequencer |
| trig_out | output | 1 | Stretched trigger for cascaded channels |

## Verification
The checks assume that `mode` and `level_sel` stay constant from the cycle `arm` is sampled until the resulting pulse. The source and sample-qualifier properties look back one cycle at those settings. The stimulus changes settings only while the unit is idle or is being re-armed. It changes `ext_trig_in` only one time unit after a clock edge, so the synchronizer latency is deterministic.

// File: rtl/acq_trigger_pkg.sv
package acq_trigger_pkg;

    localparam int SAMPLE_W   = 6;
    localparam int SEL_W      = 3;
    localparam int NUM_LEVELS = 5;
    localparam int LEVEL_BASE = 8;
    localparam int LEVEL_STEP = 12;

    typedef enum logic [2:0] {
        TM_AUTO     = 3'd0,
        TM_INT_RISE = 3'd1,
        TM_INT_FALL = 3'd2,
        TM_EXT_RISE = 3'd3,
        TM_EXT_FALL = 3'd4
    } trig_mode_e;

    typedef struct packed {
        logic [SAMPLE_W:0] lo;
        logic [SAMPLE_W:0] hi;
    } thresh_t;

    typedef struct packed {
        logic use_level;
        logic use_ext;
        logic use_timer;
        logic falling;
    } src_sel_t;

    function automatic logic [SAMPLE_W-1:0] level_code(input logic [SEL_W-1:0] sel);
        int idx;
        idx = (int'(sel) > NUM_LEVELS - 1) ? NUM_LEVELS - 1 : int'(sel);
        return SAMPLE_W'(LEVEL_BASE + LEVEL_STEP * idx);
    endfunction

    function automatic thresh_t make_thresh(input logic [SEL_W-1:0] sel, input int hyst);
        thresh_t t;
        logic [SAMPLE_W:0] c;
        c    = {1'b0, level_code(sel)};
        t.lo = c - (SAMPLE_W+1)'(hyst);
        t.hi = c + (SAMPLE_W+1)'(hyst);
        return t;
    endfunction

    function automatic src_sel_t decode_mode(input trig_mode_e m, input logic legal);
        src_sel_t s;
        s = '0;
        if (legal) begin
            case (m)
                TM_AUTO:     begin s.use_level = 1'b1; s.use_timer = 1'b1; end
                TM_INT_RISE: s.use_level = 1'b1;
                TM_INT_FALL: begin s.use_level = 1'b1; s.falling = 1'b1; end
                TM_EXT_RISE: s.use_ext = 1'b1;
                TM_EXT_FALL: begin s.use_ext = 1'b1; s.falling = 1'b1; end
                default:     s = '0;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/trig_level_cmp.sv
module trig_level_cmp
    import acq_trigger_pkg::*;
#(
    parameter int HYST = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                arm,
    input  logic                armed,
    input  logic                falling,
    input  logic [SEL_W-1:0]    level_sel,
    input  logic [SAMPLE_W-1:0] sample,
    input  logic                sample_vld,
    output logic                hit
);
    thresh_t           th;
    logic [SAMPLE_W:0] s_ext;
    logic              at_low;
    logic              at_high;
    logic              prime_cond;
    logic              cross_cond;
    logic              primed;
    logic              active;

    assign th         = make_thresh(level_sel, HYST);
    assign s_ext      = {1'b0, sample};
    assign at_low     = (s_ext <= th.lo);
    assign at_high    = (s_ext >= th.hi);
    assign prime_cond = falling ? at_high : at_low;
    assign cross_cond = falling ? at_low  : at_high;
    assign active     = armed && sample_vld && !arm;
    assign hit        = active && primed && cross_cond;

    always_ff @(posedge clk) begin
        if (rst || arm) begin
            primed <= 1'b0;
        end else if (active) begin
            if (primed && cross_cond) begin
                primed <= 1'b0;
            end else if (prime_cond) begin
                primed <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/trig_ext_sync.sv
module trig_ext_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ext_in,
    input  logic falling,
    output logic edge_det
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   cur;

    assign cur = sync_q[SYNC_STAGES-1];

    generate
        if (SYNC_STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= ext_in;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= {sync_q[SYNC_STAGES-2:0], ext_in};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= cur;
    end

    assign edge_det = falling ? (prev_q && !cur) : (!prev_q && cur);
endmodule

// File: rtl/trig_auto_timer.sv
module trig_auto_timer #(
    parameter int AUTO_TIMEOUT = 65536
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic armed,
    output logic expire
);
    localparam int            CW   = $clog2(AUTO_TIMEOUT + 1);
    localparam logic [CW-1:0] LAST = CW'(AUTO_TIMEOUT - 1);

    logic [CW-1:0] cnt_q;

    assign expire = armed && !arm && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || arm) begin
            cnt_q <= '0;
        end else if (armed && (cnt_q != LAST)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/trig_out_stretch.sv
module trig_out_stretch #(
    parameter int STRETCH = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    output logic out
);
    localparam int            SW   = $clog2(STRETCH + 1);
    localparam logic [SW-1:0] LOAD = SW'(STRETCH);

    logic [SW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (fire) begin
            cnt_q <= LOAD;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign out = (cnt_q != '0);
endmodule

// File: rtl/acq_trigger.sv
module acq_trigger
    import acq_trigger_pkg::*;
#(
    parameter int AUTO_TIMEOUT = 65536,
    parameter int STRETCH      = 4,
    parameter int SYNC_STAGES  = 2,
    parameter int HYST         = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                arm,
    input  logic [2:0]          mode,
    input  logic [SEL_W-1:0]    level_sel,
    input  logic [SAMPLE_W-1:0] sample,
    input  logic                sample_vld,
    input  logic                ext_trig_in,
    output logic                trig_pulse,
    output logic                trig_out
);
    trig_mode_e mode_e;
    src_sel_t   src;
    logic       armed_q;
    logic       lvl_hit;
    logic       ext_edge;
    logic       tmo;
    logic       fire;
    logic       pulse_q;

    assign mode_e = trig_mode_e'(mode);
    assign src    = decode_mode(mode_e, mode <= 3'd4);

    trig_level_cmp #(.HYST(HYST)) u_level (
        .clk        (clk),
        .rst        (rst),
        .arm        (arm),
        .armed      (armed_q),
        .falling    (src.falling),
        .level_sel  (level_sel),
        .sample     (sample),
        .sample_vld (sample_vld),
        .hit        (lvl_hit)
    );

    trig_ext_sync #(.SYNC_STAGES(SYNC_STAGES)) u_ext (
        .clk      (clk),
        .rst      (rst),
        .ext_in   (ext_trig_in),
        .falling  (src.falling),
        .edge_det (ext_edge)
    );

    trig_auto_timer #(.AUTO_TIMEOUT(AUTO_TIMEOUT)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .arm    (arm),
        .armed  (armed_q),
        .expire (tmo)
    );

    assign fire = armed_q && !arm &&
                  ((src.use_level && lvl_hit) ||
                   (src.use_ext   && ext_edge) ||
                   (src.use_timer && tmo));

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= fire;
            if (arm)       armed_q <= 1'b1;
            else if (fire) armed_q <= 1'b0;
        end
    end

    trig_out_stretch #(.STRETCH(STRETCH)) u_stretch (
        .clk  (clk),
        .rst  (rst),
        .fire (fire),
        .out  (trig_out)
    );

    assign trig_pulse = pulse_q;
endmodule

// File: rtl/acq_trigger_chk.sv
module acq_trigger_chk (
    input logic       clk,
    input logic       rst,
    input logic [2:0] mode,
    input logic       sample_vld,
    input logic       trig_pulse,
    input logic       trig_out
);
    logic rst_seen_q;

    always_ff @(posedge clk) rst_seen_q <= rst;

    // R1: outputs quiet right after reset
    always @(posedge clk) begin
        if (rst_seen_q === 1'b1) begin
            p_reset_quiet_r1: assert (!trig_pulse && !trig_out);
        end
    end

    // R6: pulse is one cycle wide
    p_pulse_single_r6: assert property (@(posedge clk) disable iff (rst)
        trig_pulse |=> !trig_pulse);

    // R10: trigger output accompanies the pulse
    p_out_with_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        trig_pulse |-> trig_out);

    // R11: reserved mode codes never produce a start
    p_no_reserved_r11: assert property (@(posedge clk) disable iff (rst)
        trig_pulse |-> ($past(mode) <= 3'd4));

    // R5: internal-level starts need a qualified sample
    p_level_needs_vld_r5: assert property (@(posedge clk) disable iff (rst)
        (trig_pulse && ($past(mode) == 3'd1 || $past(mode) == 3'd2)) |-> $past(sample_vld));
endmodule

bind acq_trigger acq_trigger_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .mode       (mode),
    .sample_vld (sample_vld),
    .trig_pulse (trig_pulse),
    .trig_out   (trig_out)
);

// File: tb/acq_trigger_bench.sv
module acq_trigger_bench;
    localparam int T  = 65536;
    localparam int ST = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       arm = 1'b0;
    logic [2:0] mode = 3'd0;
    logic [2:0] level_sel = 3'd0;
    logic [5:0] sample = 6'd0;
    logic       sample_vld = 1'b0;
    logic       ext_trig_in = 1'b0;
    logic       trig_pulse;
    logic       trig_out;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    acq_trigger u_acq_trigger (
        .clk (clk), .rst (rst), .arm (arm), .mode (mode), .level_sel (level_sel),
        .sample (sample), .sample_vld (sample_vld), .ext_trig_in (ext_trig_in),
        .trig_pulse (trig_pulse), .trig_out (trig_out)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic do_arm();
        arm = 1'b1; step(); arm = 1'b0;
    endtask

    task automatic feed(input int s);
        sample = 6'(s); sample_vld = 1'b1; step(); sample_vld = 1'b0;
    endtask

    function automatic int lvl(input int sel);
        return 8 + 12 * ((sel > 4) ? 4 : sel);
    endfunction

    task automatic quiet(input string tag, input int cycles);
        int seen;
        seen = 0;
        for (int i = 0; i < cycles; i++) begin
            step();
            if (trig_pulse) seen++;
        end
        chk(tag, seen, 0);
    endtask

    task automatic stretch_check();
        int w;
        w = 0;
        chk("R10 out with pulse", int'(trig_out), 1);
        while (trig_out && w < 50) begin
            w++; step();
        end
        chk("R10 out width", w, ST);
        // the pulse is gone after its first cycle
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int L, n;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        chk("R1 pulse after reset", int'(trig_pulse), 0);
        chk("R1 out after reset", int'(trig_out), 0);
        mode = 3'd1; level_sel = 3'd2;
        feed(29); feed(35);
        chk("R1 disarmed crossing", int'(trig_pulse), 0);

        // R2/R3/R4/R6/R5 sweep over every select code, both directions
        for (int sel = 0; sel < 8; sel++) begin
            for (int dir = 0; dir < 2; dir++) begin
                L = lvl(sel);
                level_sel = 3'(sel);
                mode = (dir == 0) ? 3'd1 : 3'd2;
                do_arm();
                if (dir == 0) begin
                    feed(L - 1); feed(L + 2);
                    chk("R3 no prime inside band", int'(trig_pulse), 0);
                    feed(L - 2); feed(L + 1);
                    chk("R3 below upper bound", int'(trig_pulse), 0);
                    sample = 6'(L + 2); step();
                    chk("R5 invalid sample ignored", int'(trig_pulse), 0);
                    feed(L + 2);
                    chk("R2 R3 rising trigger", int'(trig_pulse), 1);
                end else begin
                    feed(L + 1); feed(L - 2);
                    chk("R4 no prime inside band", int'(trig_pulse), 0);
                    feed(L + 2); feed(L - 1);
                    chk("R4 above lower bound", int'(trig_pulse), 0);
                    sample = 6'(L - 2); step();
                    chk("R5 invalid sample ignored", int'(trig_pulse), 0);
                    feed(L - 2);
                    chk("R2 R4 falling trigger", int'(trig_pulse), 1);
                end
                stretch_check();
                chk("R6 single pulse", int'(trig_pulse), 0);
                if (dir == 0) begin feed(L - 2); feed(L + 2); end
                else          begin feed(L + 2); feed(L - 2); end
                chk("R6 no retrigger", int'(trig_pulse), 0);
            end
        end

        // R12: re-arm clears priming
        mode = 3'd1; level_sel = 3'd1; L = lvl(1);
        do_arm(); feed(L - 2); do_arm(); feed(L + 2);
        chk("R12 priming cleared", int'(trig_pulse), 0);
        feed(L - 2); feed(L + 2);
        chk("R12 trigger after re-arm", int'(trig_pulse), 1);
        step();

        // R7: external rising
        mode = 3'd3; ext_trig_in = 1'b0; repeat (5) step();
        do_arm();
        ext_trig_in = 1'b1;
        step(); chk("R7 edge 1", int'(trig_pulse), 0);
        step(); chk("R7 edge 2", int'(trig_pulse), 0);
        step(); chk("R7 edge 3 pulse", int'(trig_pulse), 1);
        step(); chk("R6 ext single", int'(trig_pulse), 0);
        ext_trig_in = 1'b0; repeat (3) step(); ext_trig_in = 1'b1;
        quiet("R8 disarmed ext edge", 8);

        // R8: external falling
        mode = 3'd4; repeat (5) step();
        do_arm();
        ext_trig_in = 1'b0;
        step(); chk("R8 edge 1", int'(trig_pulse), 0);
        step(); chk("R8 edge 2", int'(trig_pulse), 0);
        step(); chk("R8 edge 3 pulse", int'(trig_pulse), 1);
        step();

        // R11: reserved codes
        for (int m = 5; m < 8; m++) begin
            mode = 3'(m); level_sel = 3'd2; L = lvl(2);
            do_arm();
            feed(L - 2); feed(L + 2); feed(L - 2);
            ext_trig_in = ~ext_trig_in;
            quiet("R11 reserved mode", 20);
        end

        // R9: automatic early trigger
        mode = 3'd0; level_sel = 3'd3; L = lvl(3);
        do_arm(); feed(L - 2); feed(L + 2);
        chk("R9 auto early crossing", int'(trig_pulse), 1);
        step();

        // R9 + R12: timeout measured from the re-arm edge
        do_arm();
        repeat (100) step();
        do_arm();
        n = 0;
        for (int i = 1; i <= T + 10; i++) begin
            step();
            if (trig_pulse) begin n = i; break; end
        end
        chk("R9 R12 auto timeout", n, T);
        stretch_check();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule